// File: doc/BRIEF.md
# Audio Master Clock Divider

This block turns a single fast source clock into the three clocks an audio serial link needs. The source clock runs at a fixed oversampling ratio of the sample rate, either 512x or 384x, and one family-select input tells the block which. From that source it produces a master clock for an external converter, a bit clock and a frame (left/right) clock. All outputs are registered in the source clock domain. The master clock comes out as a one-cycle enable pulse. The bit and frame clocks come out as levels.

The master clock rate is the family ratio divided by a power of two, chosen by a 3-bit multiplier code. The frame carries either 32 bit clocks (16-bit samples) or 48 bit clocks (20- and 24-bit samples). Bit-clock edges come from a phase accumulator. Every frame is therefore exactly one sample period of source cycles long, even where the ratio is not an integer, as in 512x with 48 bits. A run input and a clock-gate input start and stop all outputs. Every stop clears the counters, so a restart begins at a known phase. Codes that the selected family cannot produce are flagged and keep the master clock quiet.

Top module: `aclk_divider`

## Requirements
- R1: While `rst` is high, `mclk_en`, `bclk`, `fclk` and `cfg_err` are all 0 at the next clock edge, whatever `run` and `gate` are.
- R2: With `fam_lo`=0 (512x family) and `mult_code` c in 0..4, counting active edges k from 0, `mclk_en` is 1 after edge k exactly when k mod 2^c = 0. This gives a master clock of 512/2^c times the sample rate.
- R3: With `fam_lo`=1 (384x family) and `mult_code` c in 0..3, `mclk_en` follows the same rule as R2. This gives 384/2^c times the sample rate.
- R4: A code above 4 in the 512x family, or above 3 in the 384x family, is illegal. After each edge at which the configuration is illegal, `cfg_err` is 1 and `mclk_en` is 0. After an edge with a legal configuration, `cfg_err` is 0.
- R5: With `wide`=0, let N be the family ratio (512 or 384) and T(k) = floor((k+1)*64/N). After active edge k, `bclk` equals T(k) mod 2. This gives 32 bit clocks per N source cycles.
- R6: With `wide`=1, the same holds with T(k) = floor((k+1)*96/N). This gives 48 bit clocks per N source cycles, including the non-integer 512x case.
- R7: `fclk` toggles once every B bit-clock half-periods, where B is 32 or 48. After active edge k it equals floor(T(k)/B) mod 2. Its period is therefore exactly N source cycles.
- R8: After any edge at which `gate` is 1, `mclk_en`, `bclk` and `fclk` are 0.
- R9: After any edge at which `run` is 0, all three clock outputs are 0. The first active edge after a stop or gate is edge k=0 of R2 to R7, so outputs restart phase-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, 512x or 384x the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables clock generation when high |
| gate | input | 1 | Forces all clocks low and clears counters when high |
| fam_lo | input | 1 | Family select: 0 = 512x source, 1 = 384x source |
| mult_code | input | 3 | Power-of-two master clock divide code |
| wide | input | 1 | 0 = 32 bit clocks per frame, 1 = 48 |
| mclk_en | output | 1 | One-cycle master clock pulse |
| bclk | output | 1 | Bit clock level |
| fclk | output | 1 | Frame clock level |
| cfg_err | output | 1 | Family and code combination is illegal |

## Verification
The bench builds the block with its default parameters: 512x and 384x families, 32- and 48-bit frames, and a 3-bit code. That makes the full configuration space of 2 x 2 x 8 small enough to sweep completely. Each configuration runs for just over two frames, with the expected outputs computed from the accumulator formula for every edge. This covers every legal and illegal code, the uneven 512/48 bit-clock spacing, and frame-clock wrap in both families. Separate runs stop the block mid-frame through the gate input and through the run input, then check the restart from phase zero.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int FRAME_HI_DEF    = 512;
    localparam int FRAME_LO_DEF    = 384;
    localparam int BITS_N_DEF      = 32;
    localparam int BITS_W_DEF      = 48;
    localparam int CODE_W          = 3;
    localparam int CODE_MAX_HI_DEF = 4;
    localparam int CODE_MAX_LO_DEF = 3;

    typedef enum logic {
        FAM_HI = 1'b0,
        FAM_LO = 1'b1
    } fam_e;

    typedef struct packed {
        fam_e              fam;
        logic              wide;
        logic [CODE_W-1:0] code;
    } clk_cfg_t;

    function automatic logic code_ok(clk_cfg_t cfg, int max_hi, int max_lo);
        int lim;
        lim = (cfg.fam == FAM_LO) ? max_lo : max_hi;
        return int'(cfg.code) <= lim;
    endfunction

endpackage

// File: rtl/aclk_mclk_div.sv
module aclk_mclk_div #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              ok,
    input  logic [CODE_W-1:0] code,
    output logic              mclk_en
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    assign mask = ~({CNT_W{1'b1}} << code);

    always_ff @(posedge clk) begin
        if (rst || !active || !ok) begin
            cnt     <= '0;
            mclk_en <= 1'b0;
        end else begin
            mclk_en <= (cnt == '0);
            cnt     <= (cnt + 1'b1) & mask;
        end
    end
endmodule

// File: rtl/aclk_bclk_gen.sv
module aclk_bclk_gen #(
    parameter int ACC_W    = 10,
    parameter int FRAME_HI = 512,
    parameter int FRAME_LO = 384,
    parameter int BITS_N   = 32,
    parameter int BITS_W   = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic fam_lo,
    input  logic wide,
    output logic bclk,
    output logic step
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] frame;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    assign frame = fam_lo ? ACC_W'(FRAME_LO) : ACC_W'(FRAME_HI);
    assign inc   = wide ? ACC_W'(2 * BITS_W) : ACC_W'(2 * BITS_N);
    assign sum   = acc + inc;
    assign wrap  = (sum >= frame);
    assign step  = active && wrap;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc  <= '0;
            bclk <= 1'b0;
        end else if (wrap) begin
            acc  <= sum - frame;
            bclk <= ~bclk;
        end else begin
            acc  <= sum;
        end
    end
endmodule

// File: rtl/aclk_fclk_gen.sv
module aclk_fclk_gen #(
    parameter int CNT_W  = 6,
    parameter int BITS_N = 32,
    parameter int BITS_W = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic wide,
    input  logic step,
    output logic fclk
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim = wide ? CNT_W'(BITS_W - 1) : CNT_W'(BITS_N - 1);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt  <= '0;
            fclk <= 1'b0;
        end else if (step) begin
            if (cnt == lim) begin
                cnt  <= '0;
                fclk <= ~fclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aclk_divider.sv
module aclk_divider
    import aclk_pkg::*;
#(
    parameter int FRAME_HI    = FRAME_HI_DEF,
    parameter int FRAME_LO    = FRAME_LO_DEF,
    parameter int BITS_N      = BITS_N_DEF,
    parameter int BITS_W      = BITS_W_DEF,
    parameter int CODE_MAX_HI = CODE_MAX_HI_DEF,
    parameter int CODE_MAX_LO = CODE_MAX_LO_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              gate,
    input  logic              fam_lo,
    input  logic [CODE_W-1:0] mult_code,
    input  logic              wide,
    output logic              mclk_en,
    output logic              bclk,
    output logic              fclk,
    output logic              cfg_err
);
    localparam int MC_W  = CODE_MAX_HI;
    localparam int ACC_W = $clog2(FRAME_HI + 2 * BITS_W + 1);
    localparam int FC_W  = $clog2(BITS_W);

    clk_cfg_t cfg;
    logic     active;
    logic     ok;
    logic     step;

    assign cfg.fam  = fam_e'(fam_lo);
    assign cfg.wide = wide;
    assign cfg.code = mult_code;
    assign active   = run && !gate;
    assign ok       = code_ok(cfg, CODE_MAX_HI, CODE_MAX_LO);

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= !ok;
    end

    aclk_mclk_div #(
        .CODE_W(CODE_W),
        .CNT_W (MC_W)
    ) u_mclk (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .ok     (ok),
        .code   (cfg.code),
        .mclk_en(mclk_en)
    );

    aclk_bclk_gen #(
        .ACC_W   (ACC_W),
        .FRAME_HI(FRAME_HI),
        .FRAME_LO(FRAME_LO),
        .BITS_N  (BITS_N),
        .BITS_W  (BITS_W)
    ) u_bclk (
        .clk   (clk),
        .rst   (rst),
        .active(active),
        .fam_lo(cfg.fam == FAM_LO),
        .wide  (cfg.wide),
        .bclk  (bclk),
        .step  (step)
    );

    aclk_fclk_gen #(
        .CNT_W (FC_W),
        .BITS_N(BITS_N),
        .BITS_W(BITS_W)
    ) u_fclk (
        .clk   (clk),
        .rst   (rst),
        .active(active),
        .wide  (cfg.wide),
        .step  (step),
        .fclk  (fclk)
    );
endmodule

// File: rtl/aclk_divider_chk.sv
module aclk_divider_chk #(
    parameter int CODE_MAX_HI = 4,
    parameter int CODE_MAX_LO = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       run,
    input logic       gate,
    input logic       fam_lo,
    input logic [2:0] mult_code,
    input logic       wide,
    input logic       mclk_en,
    input logic       bclk,
    input logic       fclk,
    input logic       cfg_err
);
    logic act;
    logic legal;

    assign act   = run && !gate;
    assign legal = fam_lo ? (int'(mult_code) <= CODE_MAX_LO)
                          : (int'(mult_code) <= CODE_MAX_HI);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(act) |-> (!mclk_en && !bclk && !fclk)); // R8

    AST_ERR_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        !legal |=> cfg_err); // R4

    AST_ERR_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        legal |=> !cfg_err); // R4

    AST_ERR_NO_MCLK: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !mclk_en); // R4

    AST_FCLK_WITH_BCLK: assert property (@(posedge clk) disable iff (rst)
        ($past(act) && !$stable(fclk)) |-> !$stable(bclk)); // R7

    AST_MCLK_FIRST: assert property (@(posedge clk) disable iff (rst)
        ($rose(act) && legal) |=> mclk_en); // R9
endmodule

bind aclk_divider aclk_divider_chk #(
    .CODE_MAX_HI(CODE_MAX_HI),
    .CODE_MAX_LO(CODE_MAX_LO)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .gate     (gate),
    .fam_lo   (fam_lo),
    .mult_code(mult_code),
    .wide     (wide),
    .mclk_en  (mclk_en),
    .bclk     (bclk),
    .fclk     (fclk),
    .cfg_err  (cfg_err)
);

// File: tb/test_aclk_divider.sv
module test_aclk_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       gate = 1'b0;
    logic       fam_lo = 1'b0;
    logic [2:0] mult_code = 3'd0;
    logic       wide = 1'b0;
    logic       mclk_en, bclk, fclk, cfg_err;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    aclk_divider i_aclk_divider (
        .clk(clk), .rst(rst), .run(run), .gate(gate), .fam_lo(fam_lo),
        .mult_code(mult_code), .wide(wide), .mclk_en(mclk_en),
        .bclk(bclk), .fclk(fclk), .cfg_err(cfg_err)
    );

    function automatic bit is_legal(int f, int c);
        return (f != 0) ? (c <= 3) : (c <= 4);
    endfunction

    task automatic check_bit(string tag, string name, logic act, logic exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, name, act, exp, $time);
        end
    endtask

    // Expected outputs after active edge k: R2, R3, R4, R5, R6, R7
    task automatic check_k(int k, int f, int c, int w);
        int  n, b, t;
        bit  exp_m;
        n = (f != 0) ? 384 : 512;
        b = (w != 0) ? 48 : 32;
        t = ((k + 1) * 2 * b) / n;
        exp_m = is_legal(f, c) && ((k % (1 << c)) == 0);
        vectors++;
        check_bit(!is_legal(f, c) ? "R4" : ((f != 0) ? "R3" : "R2"), "mclk_en", mclk_en, exp_m);
        check_bit((w != 0) ? "R6" : "R5", "bclk", bclk, logic'(t % 2));
        check_bit("R7", "fclk", fclk, logic'((t / b) % 2));
    endtask

    task automatic check_quiet(string tag);
        vectors++;
        check_bit(tag, "mclk_en", mclk_en, 1'b0);
        check_bit(tag, "bclk", bclk, 1'b0);
        check_bit(tag, "fclk", fclk, 1'b0);
    endtask

    task automatic run_cfg(int f, int c, int w, int len);
        run = 1'b0;
        fam_lo = logic'(f);
        mult_code = 3'(c);
        wide = logic'(w);
        @(negedge clk);
        vectors++;
        check_bit("R4", "cfg_err", cfg_err, logic'(!is_legal(f, c)));
        check_quiet("R9");
        run = 1'b1;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            check_k(k, f, c, w);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset dominates run
        run = 1'b1;
        repeat (3) @(negedge clk);
        vectors++;
        check_bit("R1", "cfg_err", cfg_err, 1'b0);
        check_quiet("R1");
        rst = 1'b0;
        run = 1'b0;

        // Full configuration sweep
        for (int f = 0; f < 2; f++)
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 8; c++)
                    run_cfg(f, c, w, ((f != 0) ? 768 : 1024) + 3);

        // R8 gate mid-frame, then R9 phase-aligned restart
        run_cfg(0, 2, 1, 301);
        gate = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_quiet("R8");
        end
        gate = 1'b0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            check_k(k, 0, 2, 1); // R9
        end

        // R9 run drop mid-frame and restart
        run_cfg(1, 1, 0, 217);
        run = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_quiet("R9");
        end
        run = 1'b1;
        for (int k = 0; k < 800; k++) begin
            @(negedge clk);
            check_k(k, 1, 1, 0); // R9
        end

        // R4: illegal code switched in while running keeps mclk quiet
        mult_code = 3'd6;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            vectors++;
            check_bit("R4", "cfg_err", cfg_err, 1'b1);
            check_bit("R4", "mclk_en", mclk_en, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule